// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter Pair

This block holds two timer/counter channels. Each channel has a high byte and a low byte. The channels share one mode register and one control register, and that control register holds each channel's run bit and overflow flag. A channel counts one of two sources: the internal tick strobe `tick_en`, which is high for one clock per peripheral cycle, or falling edges on its external count pin. An active-high gate pin can also hold off counting. Each channel picks one of four modes: a 13-bit counter with a 5-bit prescaler, a 16-bit cascade, an 8-bit counter that reloads itself, and a mode 3 that splits channel 0 and halts channel 1.

Software reaches the registers over a simple write/read bus. Read data is registered, so it appears one clock after the address. Each overflow flag drives a registered interrupt request, and a per-channel acknowledge input clears the flag. When channel 0 is in mode 3, its high byte becomes a separate 8-bit tick timer that uses channel 1's run bit and overflow flag. Channel 1 then stops and keeps its count.

Top module: `dual_timer_pair`

## Requirements
- R1: In mode 0 (mode field 2'b00), each counting step increments the low byte's bits 4:0. When those bits wrap from 31 to 0, the high byte increments. The overflow flag sets when the high byte is 0xFF and the prescaler wraps. Low-byte bits 7:5 never change by counting.
- R2: In mode 1 (2'b01), high:low form one 16-bit counter. The overflow flag sets when it wraps from 0xFFFF to 0x0000.
- R3: In mode 2 (2'b10), only the low byte counts. When it wraps past 0xFF, it loads the high byte's value and the flag sets. The high byte is never altered by counting.
- R4: In mode 3 (2'b11), channel 0's low byte counts as an 8-bit counter under channel 0's own gate, source, run bit and flag. Channel 0's high byte counts ticks whenever run bit 1 is set, and its wrap from 0xFF sets flag 1.
- R5: Channel 1 holds its count, whatever its run bit, while its own mode is 3 or while channel 0's mode is 3.
- R6: The mode register is at address 0. Its bits 7..0 are gate1, source1, mode1[1:0], gate0, source0, mode0[1:0]. A source bit of 1 selects the external pin. The control register is at address 1, with bit 7 flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0; bits 3:0 read as 0. Channel 0 low and high bytes are at addresses 2 and 3, and channel 1's at 4 and 5. Read data appears one clock after the address.
- R7: Count pins pass through a two-stage synchronizer. The synchronized level is sampled on each tick. A count occurs only when one sample is 1 and the next is 0, so a pulse that no tick sampled is never counted.
- R8: With the gate bit set, a channel counts only while its run bit is 1 and its synchronized gate pin is high. With the gate bit clear, the run bit alone enables counting.
- R9: After reset, every register, flag and request reads 0. Setting a run bit leaves the count bytes unchanged.
- R10: Asserting `int_ack[i]` clears flag i unless a new overflow sets it in that cycle. `irq[i]` is high exactly when flag i, `int_en[i]` and `int_glob_en` are all 1.
- R11: A bus write to a count byte cancels that counter's step in the same cycle, and the written value is kept. A bus write to the control register sets the flags to the written values, overriding any overflow in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Internal tick strobe, one clock per peripheral cycle |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| int_ack | input | 2 | Per-channel interrupt acknowledge |
| int_en | input | 2 | Per-channel interrupt enable |
| int_glob_en | input | 1 | Global interrupt enable |
| ovf_flag | output | 2 | Overflow flags |
| irq | output | 2 | Interrupt requests |

## Verification
The assertions check properties that hold in every cycle:
- counting never touches the reload byte in mode 2 or the top three prescaler bits in mode 0;
- channel 1 stays frozen while channel 0 is split or channel 1 is halted;
- a closed gate stops the count;
- two falling-edge counts are never produced back to back;
- an acknowledge clears a flag;
- a request never appears without its flag.

Only the bench scenarios show the following:
- the exact count values and overflow points in each mode;
- the reload value;
- the synchronizer and sampling latency of external edges;
- the write-over-hardware priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_CAS16   = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT   = 2'd3
  } tmr_mode_e;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE   = 5,
  parameter bit SPLIT = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  tmr_mode_e mode,
  input  logic      step_main,
  input  logic      step_aux,
  input  logic      wr_lo,
  input  logic      wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic      ovf_main,
  output logic      ovf_aux
);

  localparam logic [2*W-1:0] ONE_WIDE = {{(2*W-1){1'b0}}, 1'b1};

  logic [W-1:0] lo_n, hi_n;
  logic         go_m, go_a;

  always_comb begin
    lo_n     = lo;
    hi_n     = hi;
    ovf_main = 1'b0;
    ovf_aux  = 1'b0;
    go_m     = step_main & ~wr_lo & ~wr_hi;
    go_a     = 1'b0;
    unique case (mode)
      MD_PRE13: if (go_m) begin
        lo_n[PRE-1:0] = lo[PRE-1:0] + 1'b1;
        if (&lo[PRE-1:0]) begin
          hi_n = hi + 1'b1;
          if (&hi) ovf_main = 1'b1;
        end
      end
      MD_CAS16: if (go_m) begin
        {hi_n, lo_n} = {hi, lo} + ONE_WIDE;
        if (&{hi, lo}) ovf_main = 1'b1;
      end
      MD_RELOAD8: if (go_m) begin
        if (&lo) begin
          lo_n     = hi;
          ovf_main = 1'b1;
        end else begin
          lo_n = lo + 1'b1;
        end
      end
      MD_SPLIT: if (SPLIT) begin
        go_m = step_main & ~wr_lo;
        go_a = step_aux & ~wr_hi;
        if (go_m) begin
          lo_n = lo + 1'b1;
          if (&lo) ovf_main = 1'b1;
        end
        if (go_a) begin
          hi_n = hi + 1'b1;
          if (&hi) ovf_aux = 1'b1;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  AST_M0_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PRE13 && !wr_lo) |=> lo[W-1:PRE] == $past(lo[W-1:PRE])); // R1

  AST_M2_RELOAD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_RELOAD8 && !wr_hi) |=> $stable(hi)); // R3

  generate
    if (!SPLIT) begin : g_halt
      AST_M3_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi))); // R5
    end
  endgenerate

endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair
  import tmr_pkg::*;
#(
  parameter int W      = 8,
  parameter int PRE    = 5,
  parameter int SYNC   = 2,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    gate_pin,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [1:0]    int_ack,
  input  logic [1:0]    int_en,
  input  logic          int_glob_en,
  output logic [1:0]    ovf_flag,
  output logic [1:0]    irq
);

  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_LO0  = AW'(2);
  localparam logic [AW-1:0] A_HI0  = AW'(3);
  localparam logic [AW-1:0] A_LO1  = AW'(4);
  localparam logic [AW-1:0] A_HI1  = AW'(5);
  localparam int FLD = W / 2;

  logic [W-1:0] mode_q;
  logic [1:0]   tr_q, tf_q, tf_n, set_tf;
  logic [1:0]   gate_b, src_b, gate_lvl, cnt_lvl, samp_q, fall, run, step;
  tmr_mode_e    md [2];
  logic [W-1:0] lo0, hi0, lo1, hi1, rd_mux;
  logic         ovf0_m, ovf0_a, ovf1_m, ovf1_a;
  logic         wr_mode, wr_ctrl, split0;

  assign wr_mode = bus_wr && bus_addr == A_MODE;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;

  tmr_sync #(.WIDTH(4), .STAGES(SYNC)) i_sync (
    .clk(clk), .rst(rst),
    .din({gate_pin, cnt_pin}),
    .dout({gate_lvl, cnt_lvl})
  );

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_ch_ctl
      assign gate_b[gi] = mode_q[FLD*gi+3];
      assign src_b[gi]  = mode_q[FLD*gi+2];
      assign md[gi]     = tmr_mode_e'(mode_q[FLD*gi+1 -: 2]);

      always_ff @(posedge clk) begin
        if (rst)          samp_q[gi] <= 1'b0;
        else if (tick_en) samp_q[gi] <= cnt_lvl[gi];
      end

      assign fall[gi] = tick_en & samp_q[gi] & ~cnt_lvl[gi];
      assign run[gi]  = tr_q[gi] & (~gate_b[gi] | gate_lvl[gi]);
      assign step[gi] = run[gi] & (src_b[gi] ? fall[gi] : tick_en);

      AST_EDGE_RATE: assert property (@(posedge clk) disable iff (rst)
        fall[gi] |=> !fall[gi]); // R7

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (int_ack[gi] && !set_tf[gi] && !wr_ctrl) |=> !ovf_flag[gi]); // R10

      AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq[gi] |-> ovf_flag[gi]); // R10
    end
  endgenerate

  assign split0 = (md[0] == MD_SPLIT);

  tmr_channel #(.W(W), .PRE(PRE), .SPLIT(1'b1)) i_ch0 (
    .clk(clk), .rst(rst), .mode(md[0]),
    .step_main(step[0]),
    .step_aux(tr_q[1] & tick_en),
    .wr_lo(bus_wr && bus_addr == A_LO0),
    .wr_hi(bus_wr && bus_addr == A_HI0),
    .wdata(bus_wdata),
    .lo(lo0), .hi(hi0), .ovf_main(ovf0_m), .ovf_aux(ovf0_a)
  );

  tmr_channel #(.W(W), .PRE(PRE), .SPLIT(1'b0)) i_ch1 (
    .clk(clk), .rst(rst), .mode(md[1]),
    .step_main(step[1] & ~split0),
    .step_aux(1'b0),
    .wr_lo(bus_wr && bus_addr == A_LO1),
    .wr_hi(bus_wr && bus_addr == A_HI1),
    .wdata(bus_wdata),
    .lo(lo1), .hi(hi1), .ovf_main(ovf1_m), .ovf_aux(ovf1_a)
  );

  assign set_tf = {ovf0_a | ovf1_m | ovf1_a, ovf0_m};

  always_comb begin
    tf_n = tf_q;
    for (int i = 0; i < 2; i++) begin
      if (set_tf[i])       tf_n[i] = 1'b1;
      else if (int_ack[i]) tf_n[i] = 1'b0;
    end
    if (wr_ctrl) tf_n = {bus_wdata[7], bus_wdata[5]};
  end

  always_comb begin
    unique case (bus_addr)
      A_MODE:  rd_mux = mode_q;
      A_CTRL:  rd_mux = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], {(W-4){1'b0}}};
      A_LO0:   rd_mux = lo0;
      A_HI0:   rd_mux = hi0;
      A_LO1:   rd_mux = lo1;
      A_HI1:   rd_mux = hi1;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      tr_q      <= '0;
      tf_q      <= '0;
      irq       <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_ctrl) tr_q   <= {bus_wdata[6], bus_wdata[4]};
      tf_q      <= tf_n;
      irq       <= tf_n & int_en & {2{int_glob_en}};
      bus_rdata <= rd_mux;
    end
  end

  assign ovf_flag = tf_q;

  AST_CH1_FROZEN_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (split0 && !(bus_wr && (bus_addr == A_LO1 || bus_addr == A_HI1)))
      |=> ($stable(lo1) && $stable(hi1))); // R5

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (gate_b[0] && !gate_lvl[0] && !split0 &&
     !(bus_wr && (bus_addr == A_LO0 || bus_addr == A_HI0)))
      |=> ($stable(lo0) && $stable(hi0))); // R8

endmodule

// File: tb/test_dual_timer_pair.sv
module test_dual_timer_pair;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // fields: mode[42:41] lo[40:33] hi[32:25] ticks[24:17] exp_lo[16:9] exp_hi[8:1] exp_flag0[0]
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 8'hFE, 8'hFF, 8'd2,  8'h00, 8'h00, 1'b1},
    {2'd1, 8'hFF, 8'h12, 8'd1,  8'h00, 8'h13, 1'b0},
    {2'd0, 8'hFF, 8'h10, 8'd1,  8'hE0, 8'h11, 1'b0},
    {2'd0, 8'h3F, 8'hFF, 8'd1,  8'h20, 8'h00, 1'b1},
    {2'd2, 8'hFE, 8'h80, 8'd3,  8'h81, 8'h80, 1'b1},
    {2'd2, 8'h10, 8'h55, 8'd5,  8'h15, 8'h55, 1'b0},
    {2'd3, 8'hFF, 8'h20, 8'd1,  8'h00, 8'h20, 1'b1},
    {2'd1, 8'h34, 8'h12, 8'd16, 8'h44, 8'h12, 1'b0}
  };

  logic       clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
  logic [1:0] cnt_pin = '0, gate_pin = '0, int_ack = '0, int_en = '0;
  logic       bus_wr = 1'b0, int_glob_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, r;
  logic [1:0] ovf_flag, irq;
  int total = 0, bad = 0, cyc = 0;

  dual_timer_pair i_dual_timer_pair (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_ack(int_ack), .int_en(int_en), .int_glob_en(int_glob_en),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      chk("R9", r, 8'h00);
    end
    chk("R9", {6'b0, ovf_flag}, 8'h00);
    chk("R9", {6'b0, irq}, 8'h00);

    // R6: mode register readback
    wr(3'd0, 8'hA5); rd(3'd0, r); chk("R6", r, 8'hA5);

    // vector table, channel 0, tick source, no gate
    for (int v = 0; v < NV; v++) begin
      wr(3'd1, 8'h00);
      wr(3'd0, {6'b0, VEC[v][42:41]});
      wr(3'd2, VEC[v][40:33]);
      wr(3'd3, VEC[v][32:25]);
      wr(3'd1, 8'h10);
      ticks(int'(VEC[v][24:17]));
      rd(3'd2, r); chk(mtag(VEC[v][42:41]), r, VEC[v][16:9]);
      rd(3'd3, r); chk(mtag(VEC[v][42:41]), r, VEC[v][8:1]);
      rd(3'd1, r); chk("R6", r, {2'b00, VEC[v][0], 5'h10});
    end

    // R9: setting run keeps preset
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'h5A); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10); rd(3'd2, r); chk("R9", r, 8'h5A);

    // R7: external falling edges
    wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    @(negedge clk); cnt_pin[0] = 1'b1;
    ticks(3);
    @(negedge clk); cnt_pin[0] = 1'b0;
    ticks(3);
    rd(3'd2, r); chk("R7", r, 8'h01);
    ticks(3);
    rd(3'd2, r); chk("R7", r, 8'h01);
    @(negedge clk); cnt_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    cnt_pin[0] = 1'b0;
    repeat (4) @(negedge clk);
    ticks(3);
    rd(3'd2, r); chk("R7", r, 8'h01);

    // R8: gating
    wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    ticks(4);
    rd(3'd2, r); chk("R8", r, 8'h00);
    @(negedge clk); gate_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    ticks(4);
    rd(3'd2, r); chk("R8", r, 8'h04);
    gate_pin[0] = 1'b0;

    // R4 / R5: channel 0 split, high byte on run bit 1
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    wr(3'd2, 8'h07); wr(3'd3, 8'hFF); wr(3'd4, 8'h05); wr(3'd5, 8'h00);
    wr(3'd1, 8'h40);
    ticks(1);
    rd(3'd3, r); chk("R4", r, 8'h00);
    rd(3'd2, r); chk("R4", r, 8'h07);
    rd(3'd1, r); chk("R4", r, 8'hC0);
    chk("R4", {6'b0, ovf_flag}, 8'h02);
    rd(3'd4, r); chk("R5", r, 8'h05);
    // channel 1 own mode 3 halts
    wr(3'd1, 8'h00); wr(3'd0, 8'h31); wr(3'd1, 8'h40);
    ticks(3);
    rd(3'd4, r); chk("R5", r, 8'h05);
    wr(3'd1, 8'h00); wr(3'd0, 8'h11); wr(3'd1, 8'h40);
    ticks(2);
    rd(3'd4, r); chk("R5", r, 8'h07);

    // R10: flags, enables, acknowledge
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h10);
    ticks(1);
    chk("R10", {7'b0, ovf_flag[0]}, 8'h01);
    chk("R10", {7'b0, irq[0]}, 8'h00);
    @(negedge clk); int_en = 2'b01; int_glob_en = 1'b0;
    @(negedge clk); chk("R10", {7'b0, irq[0]}, 8'h00);
    int_glob_en = 1'b1;
    @(negedge clk); chk("R10", {7'b0, irq[0]}, 8'h01);
    int_ack = 2'b01;
    @(negedge clk); int_ack = 2'b00;
    chk("R10", {7'b0, ovf_flag[0]}, 8'h00);
    chk("R10", {7'b0, irq[0]}, 8'h00);
    int_en = 2'b00; int_glob_en = 1'b0;

    // R11: bus write beats counting
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h10);
    @(negedge clk); tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h40;
    @(negedge clk); tick_en = 1'b0; bus_wr = 1'b0;
    rd(3'd2, r); chk("R11", r, 8'h40);
    rd(3'd3, r); chk("R11", r, 8'hFF);
    rd(3'd1, r); chk("R11", r, 8'h10);
    wr(3'd2, 8'hFF);
    @(negedge clk); tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h10;
    @(negedge clk); tick_en = 1'b0; bus_wr = 1'b0;
    rd(3'd1, r); chk("R11", r, 8'h10);
    rd(3'd2, r); chk("R11", r, 8'h00);
    rd(3'd3, r); chk("R11", r, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule